// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a small 8-bit CPU core and decides which interrupt the core takes next. Fourteen maskable hardware sources each keep a pending flag and an enable bit. Each flag is set by a pulse from its peripheral and cleared by that peripheral's clear pulse. The enabled flags are ORed into eight group bits, one for each hardware priority level. The group bits can be read directly as status. A software-interrupt request sits above all of them and is taken even while the CPU's global interrupt mask is set.

The block drives a single request line to the core. When the core strobes acknowledge, the block latches two things: the 16-bit vector address of the winning level, and a flag that tells the stacking sequence whether to push the program counter unchanged (software interrupt) or decremented by one (hardware interrupt). Both latched values stay constant until the next acknowledge that finds a request.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all flags and enables are zero, `irq_req` is 0, `grp_status` is 0, `vec_addr` is 16'h0000 and `stack_pc_dec` is 0.
- R2: A 1 on `src_set[i]` sets flag i at the next clock edge. The flag stays set, whether or not source i is enabled, until a 1 on `src_clr[i]`. If set and clear arrive in the same cycle, the flag ends up set.
- R3: `grp_status[g]` (level g+1) is the OR of flag&enable over its sources: bit 0 = source 0; bit 1 = sources 1..4; bit 2 = sources 5..6; bit 3 = sources 7..9; bit 4 = source 10; bit 5 = source 11; bit 6 = source 12; bit 7 = source 13.
- R4: When `en_wr` is 1, all fourteen enables take the value of `en_wdata` at the clock edge. Otherwise the enables hold.
- R5: `irq_req` is 1 exactly when a software interrupt is pending, or when `cpu_imask` is 0 and any `grp_status` bit is 1.
- R6: `swi_req` makes a software interrupt pending from the next edge. An `ack` clears it, but a `swi_req` in the same cycle as that `ack` keeps it pending.
- R7: On `ack` with `irq_req` high, `vec_addr` becomes 16'hFFFC minus twice the winning level. Level 0 is the software interrupt, which wins over everything. Otherwise the winner is the lowest-numbered set group level 1..8, and hardware levels only count when `cpu_imask` is 0.
- R8: `vec_addr` and `stack_pc_dec` change only on a clock edge where `ack` is 1 and `irq_req` is 1.
- R9: The value latched into `stack_pc_dec` is 0 when the winner is the software interrupt and 1 when it is a hardware level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_imask | input | 1 | Global interrupt mask from the CPU (1 = hardware levels blocked) |
| swi_req | input | 1 | Software-interrupt request pulse |
| ack | input | 1 | Acknowledge strobe from the CPU; latches vector and stack flag |
| src_set | input | 14 | Per-source flag set pulses from peripherals |
| src_clr | input | 14 | Per-source flag clear pulses from peripherals |
| en_wr | input | 1 | Load strobe for the enable bits |
| en_wdata | input | 14 | New enable bits |
| grp_status | output | 8 | Group status, bit g = level g+1 |
| irq_req | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Latched vector address |
| stack_pc_dec | output | 1 | Latched: 1 = stack PC minus one, 0 = stack PC |

## Verification
Two pairs of events can land in the same cycle. A peripheral can set and clear the same flag at once. A new software request can arrive on the same edge as the acknowledge that retires the previous one. Both collisions are driven on purpose in directed steps and also come up in the sparse random traffic. In each case the bench model's stated outcome (flag stays set, software interrupt stays pending) is compared with the group status and request line on the following cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int NUM_SRC = 14;
    localparam int NUM_GRP = 8;
    localparam int LVL_W   = 4;
    localparam int VEC_W   = 16;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFC;

    // group index (level minus one) for each hardware source
    function automatic int grp_of(input int s);
        int g;
        if (s == 0)       g = 0;
        else if (s <= 4)  g = 1;
        else if (s <= 6)  g = 2;
        else if (s <= 9)  g = 3;
        else              g = s - 6;
        return g;
    endfunction

    function automatic logic [NUM_SRC-1:0] grp_mask(input int g);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (grp_of(s) == g) m[s] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [LVL_W-1:0] lvl);
        return VEC_TOP - {{(VEC_W-LVL_W-1){1'b0}}, lvl, 1'b0};
    endfunction
endpackage

// File: rtl/irqv_src_bank.sv
module irqv_src_bank
    import irqv_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_set,
    input  logic [N-1:0] src_clr,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] active
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a set in the same cycle as a clear wins
            st_d.flags[i] = src_set[i] | (st_q.flags[i] & ~src_clr[i]);
        end
        if (en_wr) st_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags  = st_q.flags;
    assign active = st_q.flags & st_q.en;
endmodule

// File: rtl/irqv_group_or.sv
module irqv_group_or
    import irqv_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int G = NUM_GRP
) (
    input  logic [N-1:0] active,
    output logic [G-1:0] grp
);
    for (genvar g = 0; g < G; g++) begin : g_lvl
        localparam logic [N-1:0] MASK = grp_mask(g);
        assign grp[g] = |(active & MASK);
    end
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick
    import irqv_pkg::*;
#(
    parameter int G  = NUM_GRP,
    parameter int LW = LVL_W,
    parameter int VW = VEC_W
) (
    input  logic          swi_pend,
    input  logic          imask,
    input  logic [G-1:0]  grp,
    output logic          hit,
    output logic [LW-1:0] level,
    output logic [VW-1:0] vector
);
    always_comb begin
        hit   = 1'b0;
        level = '0;
        if (swi_pend) begin
            hit   = 1'b1;
            level = '0;
        end else if (!imask) begin
            // descending scan: the lowest set level is written last
            for (int g = G - 1; g >= 0; g--) begin
                if (grp[g]) begin
                    hit   = 1'b1;
                    level = LW'(g + 1);
                end
            end
        end
        vector = vec_of(level);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int G  = NUM_GRP,
    parameter int LW = LVL_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_imask,
    input  logic          swi_req,
    input  logic          ack,
    input  logic [N-1:0]  src_set,
    input  logic [N-1:0]  src_clr,
    input  logic          en_wr,
    input  logic [N-1:0]  en_wdata,
    output logic [G-1:0]  grp_status,
    output logic          irq_req,
    output logic [VW-1:0] vec_addr,
    output logic          stack_pc_dec
);
    typedef struct packed {
        logic          swi;
        logic [VW-1:0] vec;
        logic          dec;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [N-1:0]  src_flags;
    logic [N-1:0]  src_active;
    logic          pick_hit;
    logic [LW-1:0] pick_lvl;
    logic [VW-1:0] pick_vec;
    logic          swi_pend;

    assign swi_pend = st_q.swi;

    irqv_src_bank #(.N(N)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_set  (src_set),
        .src_clr  (src_clr),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .flags    (src_flags),
        .active   (src_active)
    );

    irqv_group_or #(.N(N), .G(G)) u_or (
        .active (src_active),
        .grp    (grp_status)
    );

    irqv_prio_pick #(.G(G), .LW(LW), .VW(VW)) u_pick (
        .swi_pend (swi_pend),
        .imask    (cpu_imask),
        .grp      (grp_status),
        .hit      (pick_hit),
        .level    (pick_lvl),
        .vector   (pick_vec)
    );

    always_comb begin
        st_d = st_q;
        if (ack && pick_hit) begin
            st_d.vec = pick_vec;
            st_d.dec = (pick_lvl != '0);
        end
        // a pending software interrupt always wins, so any ack retires it
        st_d.swi = swi_req | (st_q.swi & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req      = pick_hit;
    assign vec_addr     = st_q.vec;
    assign stack_pc_dec = st_q.dec;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
    parameter int N  = 14,
    parameter int G  = 8,
    parameter int VW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_imask,
    input logic          ack,
    input logic [N-1:0]  src_set,
    input logic [N-1:0]  src_flags,
    input logic          swi_pend,
    input logic [G-1:0]  grp_status,
    input logic          irq_req,
    input logic [VW-1:0] vec_addr,
    input logic          stack_pc_dec
);
    // R5
    hw_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_imask && grp_status != '0) |-> irq_req);

    // R5
    idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!swi_pend && grp_status == '0) |-> !irq_req);

    // R2
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((src_flags & $past(src_set)) == $past(src_set)));

    // R8
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack) |-> ($stable(vec_addr) && $stable(stack_pc_dec)));

    // R9
    swi_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && swi_pend) |=> (!stack_pc_dec && vec_addr == 16'hFFFC));
endmodule

bind irq_vector_ctrl irqv_chk #(.N(N), .G(G), .VW(VW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_imask    (cpu_imask),
    .ack          (ack),
    .src_set      (src_set),
    .src_flags    (src_flags),
    .swi_pend     (swi_pend),
    .grp_status   (grp_status),
    .irq_req      (irq_req),
    .vec_addr     (vec_addr),
    .stack_pc_dec (stack_pc_dec)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_imask = 1'b0;
    logic        swi_req = 1'b0;
    logic        ack = 1'b0;
    logic [13:0] src_set = '0;
    logic [13:0] src_clr = '0;
    logic        en_wr = 1'b0;
    logic [13:0] en_wdata = '0;
    logic [7:0]  grp_status;
    logic        irq_req;
    logic [15:0] vec_addr;
    logic        stack_pc_dec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    logic [13:0] m_flags = '0;
    logic [13:0] m_en    = '0;
    logic        m_swi   = 1'b0;
    logic [15:0] m_vec   = '0;
    logic        m_dec   = 1'b0;

    always #10 clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_imask(cpu_imask), .swi_req(swi_req),
        .ack(ack), .src_set(src_set), .src_clr(src_clr), .en_wr(en_wr),
        .en_wdata(en_wdata), .grp_status(grp_status), .irq_req(irq_req),
        .vec_addr(vec_addr), .stack_pc_dec(stack_pc_dec)
    );

    function automatic int lvl_of_src(input int s);
        case (s)
            0:          return 1;
            1, 2, 3, 4: return 2;
            5, 6:       return 3;
            7, 8, 9:    return 4;
            default:    return s - 5;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] st = '0;
        for (int s = 0; s < 14; s++)
            if (m_flags[s] && m_en[s]) st[lvl_of_src(s) - 1] = 1'b1;
        return st;
    endfunction

    function automatic int exp_level();
        logic [7:0] st = exp_status();
        if (m_swi) return 0;
        if (cpu_imask) return -1;
        for (int l = 1; l <= 8; l++)
            if (st[l - 1]) return l;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // inputs are set just after a posedge; outputs are compared mid-cycle,
    // then the model advances on the edge
    task automatic cycle();
        int lv;
        #9;
        lv = exp_level();
        chk("R3 grp_status", 32'(grp_status), 32'(exp_status()));
        chk("R5 irq_req", 32'(irq_req), 32'(lv >= 0));
        chk("R7 vec_addr", 32'(vec_addr), 32'(m_vec));
        chk("R9 stack_pc_dec", 32'(stack_pc_dec), 32'(m_dec));
        @(posedge clk);
        if (ack && lv >= 0) begin
            m_vec = 16'hFFFC - 16'(2 * lv);
            m_dec = (lv != 0);
        end
        m_swi   = swi_req | (m_swi & ~ack);
        m_flags = src_set | (m_flags & ~src_clr);
        if (en_wr) m_en = en_wdata;
        #1;
        swi_req = 1'b0; ack = 1'b0; src_set = '0; src_clr = '0; en_wr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state, with activity on the inputs
        src_set = '1; en_wr = 1'b1; en_wdata = '1; swi_req = 1'b1;
        repeat (3) @(posedge clk);
        #9;
        chk("R1 status in reset", 32'(grp_status), 0);
        chk("R1 irq in reset", 32'(irq_req), 0);
        chk("R1 vec in reset", 32'(vec_addr), 0);
        @(posedge clk); #1;
        src_set = '0; en_wr = 1'b0; en_wdata = '0; swi_req = 1'b0;
        rst_n = 1'b1;
        #9;
        chk("R1 status after reset", 32'(grp_status), 0);
        chk("R1 dec after reset", 32'(stack_pc_dec), 0);
        @(posedge clk); #1;

        // R6/R9 software interrupt through a set mask
        cpu_imask = 1'b1; swi_req = 1'b1; cycle();
        chk("R6 swi pending under mask", 32'(irq_req), 1);
        ack = 1'b1; cycle();
        chk("R9 swi stacks PC", 32'(stack_pc_dec), 0);
        chk("R7 swi vector", 32'(vec_addr), 32'h0000FFFC);
        chk("R6 swi retired", 32'(irq_req), 0);

        // R2/R4 flag held while disabled, appears when enabled
        src_set = 14'h2000; cycle();
        chk("R2 disabled flag hidden", 32'(grp_status), 0);
        en_wr = 1'b1; en_wdata = '1; cycle();
        chk("R4 enable reveals flag", 32'(grp_status), 32'h80);

        // R5 mask blocks hardware
        chk("R5 masked hw", 32'(irq_req), 0);
        cpu_imask = 1'b0; src_set = 14'h1000; cycle();
        ack = 1'b1; cycle();
        chk("R7 level 7 wins over 8", 32'(vec_addr), 32'h0000FFEE);
        chk("R9 hw stacks PC-1", 32'(stack_pc_dec), 1);

        // R2 set and clear together on source 12
        src_set = 14'h1000; src_clr = 14'h1000; cycle();
        chk("R2 set beats clear", 32'(grp_status), 32'hC0);
        src_clr = 14'h3000; cycle();
        chk("R2 clear", 32'(grp_status), 0);

        // R8 ack with nothing pending
        ack = 1'b1; cycle();
        chk("R8 vec held on idle ack", 32'(vec_addr), 32'h0000FFEE);

        // R6 new swi on the retiring ack
        swi_req = 1'b1; cycle();
        swi_req = 1'b1; ack = 1'b1; cycle();
        chk("R6 swi re-armed on ack", 32'(irq_req), 1);
        ack = 1'b1; cycle();

        // R7 all levels pending
        src_set = '1; cycle();
        ack = 1'b1; cycle();
        chk("R7 level 1 first", 32'(vec_addr), 32'h0000FFFA);
        src_clr = '1; cycle();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            src_set   = 14'($urandom & $urandom & $urandom);
            src_clr   = 14'($urandom & $urandom & $urandom);
            en_wr     = ($urandom % 8) == 0;
            en_wdata  = 14'($urandom);
            cpu_imask = ($urandom % 3) == 0;
            ack       = ($urandom % 4) == 0;
            swi_req   = ($urandom % 16) == 0;
            cycle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule